// File: doc/BRIEF.md
# Sticky Status and Command Register Block

This block is the register front end of a sensor controller. A byte-wide register bus reaches two 16-bit words: a read-only status word at byte offsets 0x3C (low byte) and 0x3D (high byte), and a write-only command word at 0x3E (low byte) and 0x3F (high byte). The status word gathers alarm and error conditions from seven event lines. The command word turns written ones into single-cycle pulses for the rest of the device.

Most status flags are sticky. They stay set until a clear command arrives, and they are set again on every cycle in which their condition is still present. The two supply-range flags do not stick: they follow their condition lines. Three of the commands start a nonvolatile store. For each store, a hold timer counts a parameterised number of cycles (50 ms at the system clock). A supply-range condition seen while that timer runs is reported as a failed control-register update.

Top module: `status_cmd_regs`

## Requirements
- R1: The status word places the event lines as follows: ev_in[0] (supply low) at bit 0, ev_in[1] (supply high) at bit 1, ev_in[2] (update failed) at bit 2, ev_in[3] (communication failure) at bit 3, ev_in[4] (self-test fail) at bit 5, ev_in[5] (alarm 1) at bit 8 and ev_in[6] (alarm 2) at bit 9. All other bits read 0. Bus reads are combinational: offset 0x3C returns bits 7:0 and offset 0x3D returns bits 15:8.
- R2: An event line that is high at a clock edge sets its flag at that edge, even when a clear takes effect at the same edge.
- R3: Status bits 0 and 1 show the value that ev_in[0] and ev_in[1] had at the previous edge, so they clear by themselves once the supply is back in range.
- R4: Status bits 2, 3, 5, 8 and 9 stay set until a clear pulse (command bit 4) or a software-reset pulse (command bit 7) is high at an edge. That edge zeroes them, except for bits whose condition is active at the same edge.
- R5: Reads at offsets 0x3E and 0x3F always return 0x00.
- R6: Writing 1 to bits of the command low byte (offset 0x3E) raises the matching outputs for exactly the one cycle after the write: bit 7 sw_reset_p, bit 4 clear_p, bit 3 nv_store_p, bit 2 dac_latch_p, bit 1 factory_p, bit 0 null_p.
- R7: Command bits 6:5, any write to offset 0x3F, and writes to the status offsets produce no pulse and leave the status unchanged.
- R8: A pulse on nv_store_p, factory_p or null_p loads the hold timer. hold_busy is then high for exactly HOLD_CYCLES cycles, counted from the cycle after the pulse. A new store pulse restarts the count.
- R9: While hold_busy is high, ev_in[0] or ev_in[1] high at an edge sets status bit 2.
- R10: A software-reset pulse also clears the sticky status flags, in the same way as the clear command.
- R11: After reset, both words read 0x0000, all pulses are low and hold_busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously inside the block |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe for one byte |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Read data byte for bus_addr (combinational) |
| ev_in | input | 7 | Condition lines: supply low, supply high, update failed, communication failure, self-test fail, alarm 1, alarm 2 |
| sw_reset_p | output | 1 | Software reset pulse |
| clear_p | output | 1 | Status clear pulse |
| nv_store_p | output | 1 | Manual nonvolatile store pulse |
| dac_latch_p | output | 1 | Auxiliary DAC latch pulse |
| factory_p | output | 1 | Factory reset pulse |
| null_p | output | 1 | Null (offset zeroing) pulse |
| hold_busy | output | 1 | High while the store hold timer runs |

## Verification
The stimulus drives single event lines that are then released, so the sticky flags can be told apart from the self-clearing supply flags. It also holds a condition high while a clear is issued, which separates "clear wins" from "set wins". Single-bit command writes, writes to the ignored bits, writes to the status offsets and writes to the high command byte show that each pulse appears on the right output only. The store commands are issued with and without a supply excursion inside the hold window, and one store is restarted mid-count, which checks both the window length and the update-failed report. Random phases then mix bus writes, changing read addresses and sparse event bursts against a cycle model built in the bench.

// File: rtl/scr_pkg.sv
package scr_pkg;

  localparam int unsigned EV_N = 7;

  // event line indices
  localparam int unsigned EV_VLOW  = 0;
  localparam int unsigned EV_VHIGH = 1;
  localparam int unsigned EV_UPD   = 2;

  // byte offsets of the two words
  localparam logic [7:0] OFS_STAT_LO = 8'h3C;
  localparam logic [7:0] OFS_STAT_HI = 8'h3D;
  localparam logic [7:0] OFS_CMD_LO  = 8'h3E;

  // command bit positions inside the low command byte
  localparam int unsigned CB_SWRST = 7;
  localparam int unsigned CB_CLR   = 4;
  localparam int unsigned CB_STORE = 3;
  localparam int unsigned CB_DAC   = 2;
  localparam int unsigned CB_FACT  = 1;
  localparam int unsigned CB_NULL  = 0;

  typedef struct packed {
    logic swrst;
    logic clr;
    logic nvstore;
    logic daclatch;
    logic factory;
    logic nul;
  } cmd_pulse_t;

  // place the seven flags at their status word positions
  function automatic logic [15:0] status_word(input logic [EV_N-1:0] f);
    logic [15:0] w;
    w      = '0;
    w[3:0] = f[3:0];
    w[5]   = f[4];
    w[8]   = f[5];
    w[9]   = f[6];
    return w;
  endfunction

endpackage

// File: rtl/scr_cmd.sv
module scr_cmd
  import scr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  output cmd_pulse_t pulse_o
);

  cmd_pulse_t pulse_d, pulse_q;

  always_comb begin
    pulse_d = '0;
    if (wr_i) begin
      pulse_d.swrst    = wdata_i[CB_SWRST];
      pulse_d.clr      = wdata_i[CB_CLR];
      pulse_d.nvstore  = wdata_i[CB_STORE];
      pulse_d.daclatch = wdata_i[CB_DAC];
      pulse_d.factory  = wdata_i[CB_FACT];
      pulse_d.nul      = wdata_i[CB_NULL];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= '0;
    else        pulse_q <= pulse_d;
  end

  assign pulse_o = pulse_q;

  // R6
  pulse_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> (pulse_q == '0));

  // R6
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_q != '0) |-> $past(wr_i));

endmodule

// File: rtl/scr_hold.sv
module scr_hold #(
  parameter int unsigned HOLD_CYCLES = 2_500_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic supply_bad_i,
  output logic busy_o,
  output logic fault_o
);

  localparam int unsigned CNT_W = $clog2(HOLD_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(HOLD_CYCLES);

  logic [CNT_W-1:0] cnt_d, cnt_q;
  logic             cnt_en;

  assign busy_o = (cnt_q != '0);
  assign cnt_en = start_i || busy_o;

  always_comb begin
    cnt_d = cnt_q;
    if (start_i)     cnt_d = CNT_LOAD;
    else if (busy_o) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign fault_o = busy_o && supply_bad_i;

  // R8
  hold_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (busy_o && cnt_q == CNT_LOAD));

  // R8
  hold_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !start_i) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/scr_status.sv
module scr_status
  import scr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [EV_N-1:0] ev_i,
  input  logic            fault_i,
  input  logic            clr_i,
  output logic [EV_N-1:0] flags_o
);

  logic [EV_N-1:0] set_v;
  logic [EV_N-1:0] flags_d, flags_q;

  always_comb begin
    set_v         = ev_i;
    set_v[EV_UPD] = ev_i[EV_UPD] | fault_i;
  end

  for (genvar k = 0; k < EV_N; k++) begin : g_flag
    if (k == EV_VLOW || k == EV_VHIGH) begin : g_follow
      // supply flags track their line
      assign flags_d[k] = set_v[k];
    end else begin : g_sticky
      // sticky flags: a clear loses against an active set
      assign flags_d[k] = (flags_q[k] & ~clr_i) | set_v[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign flags_o = flags_q;

  // R2
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_i != '0) |=> ((flags_q & $past(ev_i)) == $past(ev_i)));

  // R3
  supply_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_i[EV_VLOW] || ev_i[EV_VHIGH]) |=> !(flags_q[EV_VLOW] || flags_q[EV_VHIGH]));

  // R4
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> ((flags_q[EV_N-1:2] & $past(flags_q[EV_N-1:2])) == $past(flags_q[EV_N-1:2])));

  // R9
  hold_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_i |=> flags_q[EV_UPD]);

endmodule

// File: rtl/status_cmd_regs.sv
module status_cmd_regs
  import scr_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned HOLD_CYCLES = 2_500_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [6:0]        ev_in,
  output logic              sw_reset_p,
  output logic              clear_p,
  output logic              nv_store_p,
  output logic              dac_latch_p,
  output logic              factory_p,
  output logic              null_p,
  output logic              hold_busy
);

  localparam logic [ADDR_W-1:0] A_STAT_LO = ADDR_W'(OFS_STAT_LO);
  localparam logic [ADDR_W-1:0] A_STAT_HI = ADDR_W'(OFS_STAT_HI);
  localparam logic [ADDR_W-1:0] A_CMD_LO  = ADDR_W'(OFS_CMD_LO);

  // asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  logic            cmd_wr;
  cmd_pulse_t      pulse;
  logic            hold_start, hold_fault, supply_bad;
  logic [EV_N-1:0] flags;
  logic [15:0]     stat_w;

  assign cmd_wr = bus_we && (bus_addr == A_CMD_LO);

  scr_cmd u_cmd (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .wr_i    (cmd_wr),
    .wdata_i (bus_wdata),
    .pulse_o (pulse)
  );

  assign hold_start = pulse.nvstore | pulse.factory | pulse.nul;
  assign supply_bad = ev_in[EV_VLOW] | ev_in[EV_VHIGH];

  scr_hold #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
    .clk          (clk),
    .rst_n        (rst_n_s),
    .start_i      (hold_start),
    .supply_bad_i (supply_bad),
    .busy_o       (hold_busy),
    .fault_o      (hold_fault)
  );

  scr_status u_stat (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .ev_i    (ev_in),
    .fault_i (hold_fault),
    .clr_i   (pulse.clr | pulse.swrst),
    .flags_o (flags)
  );

  assign stat_w = status_word(flags);

  always_comb begin
    unique case (bus_addr)
      A_STAT_LO: bus_rdata = stat_w[7:0];
      A_STAT_HI: bus_rdata = stat_w[15:8];
      default:   bus_rdata = 8'h00;
    endcase
  end

  assign sw_reset_p  = pulse.swrst;
  assign clear_p     = pulse.clr;
  assign nv_store_p  = pulse.nvstore;
  assign dac_latch_p = pulse.daclatch;
  assign factory_p   = pulse.factory;
  assign null_p      = pulse.nul;

endmodule

// File: tb/sim_status_cmd_regs.sv
module sim_status_cmd_regs;

  localparam int unsigned HOLD = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [6:0] ev_in = 7'h00;
  logic [7:0] bus_rdata;
  logic       sw_reset_p, clear_p, nv_store_p, dac_latch_p, factory_p, null_p, hold_busy;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  string tag  = "R11";

  always #10 clk = ~clk;  // 50 MHz

  status_cmd_regs #(.ADDR_W(8), .HOLD_CYCLES(HOLD)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_in(ev_in),
    .sw_reset_p(sw_reset_p), .clear_p(clear_p), .nv_store_p(nv_store_p),
    .dac_latch_p(dac_latch_p), .factory_p(factory_p), .null_p(null_p),
    .hold_busy(hold_busy)
  );

  // expected state, built from the requirements
  logic [6:0]  m_f;
  logic [5:0]  m_p;   // swrst, clr, store, dac, factory, null
  int unsigned m_cnt;
  logic [6:0]  nf;

  function automatic logic [15:0] exp_word(input logic [6:0] f);
    return {6'b0, f[6], f[5], 2'b0, f[4], 1'b0, f[3:0]};
  endfunction

  function automatic logic [7:0] exp_rd(input logic [7:0] a, input logic [6:0] f);
    logic [15:0] w = exp_word(f);
    if (a == 8'h3C) return w[7:0];
    if (a == 8'h3D) return w[15:8];
    return 8'h00;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_f <= '0; m_p <= '0; m_cnt <= 0;
    end else begin
      nf = (m_p[5] | m_p[4]) ? 7'h00 : m_f;   // R4 R10
      nf[1:0] = 2'b00;                         // R3
      nf = nf | ev_in;                         // R2
      if (m_cnt != 0 && (ev_in[0] | ev_in[1])) nf[2] = 1'b1;  // R9
      m_f <= nf;
      m_p <= (bus_we && bus_addr == 8'h3E) ?
             {bus_wdata[7], bus_wdata[4], bus_wdata[3], bus_wdata[2], bus_wdata[1], bus_wdata[0]} : 6'h00;
      if (m_p[3] | m_p[1] | m_p[0]) m_cnt <= HOLD;  // R8
      else if (m_cnt != 0)          m_cnt <= m_cnt - 1;
    end
  end

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  // compare outputs, then drive the next cycle's inputs
  task automatic step(input logic we, input logic [7:0] a, input logic [7:0] d, input logic [6:0] ev);
    @(negedge clk);
    if (bus_addr == 8'h3E || bus_addr == 8'h3F)
      chk("R5", "cmd read", {8'h00, bus_rdata}, 16'h0000);
    else
      chk(tag, "rdata", {8'h00, bus_rdata}, {8'h00, exp_rd(bus_addr, m_f)});
    chk("R6", "pulses", {10'h0, sw_reset_p, clear_p, nv_store_p, dac_latch_p, factory_p, null_p},
        {10'h0, m_p});
    chk("R8", "hold_busy", {15'h0, hold_busy}, {15'h0, m_cnt != 0});
    bus_we = we; bus_addr = a; bus_wdata = d; ev_in = ev;
  endtask

  task automatic idle(input int n, input logic [7:0] a, input logic [6:0] ev);
    for (int i = 0; i < n; i++) step(1'b0, a, 8'h00, ev);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(20 * 60000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11", "rdata in reset", {8'h00, bus_rdata}, 16'h0000);
    rst_n = 1'b1;
    tag = "R11";
    idle(4, 8'h3C, 7'h00);
    idle(2, 8'h3D, 7'h00);
    // R5 command reads zero after a write
    tag = "R5";
    step(1'b1, 8'h3E, 8'h9F, 7'h00);
    idle(2, 8'h3E, 7'h00);
    idle(2, 8'h3F, 7'h00);
    idle(HOLD + 2, 8'h3C, 7'h00);
    // R6 each command bit alone
    tag = "R6";
    foreach (m_p[i]) begin
      logic [7:0] cb [6] = '{8'h80, 8'h10, 8'h08, 8'h04, 8'h02, 8'h01};
      step(1'b1, 8'h3E, cb[i], 7'h00);
      idle(2, 8'h3C, 7'h00);
    end
    idle(HOLD + 2, 8'h3C, 7'h00);
    // R7 ignored bits and offsets
    tag = "R7";
    step(1'b0, 8'h3C, 8'h00, 7'h08);
    step(1'b1, 8'h3E, 8'h60, 7'h00);
    step(1'b1, 8'h3F, 8'hFF, 7'h00);
    step(1'b1, 8'h3C, 8'hFF, 7'h00);
    step(1'b1, 8'h3D, 8'hFF, 7'h00);
    idle(3, 8'h3C, 7'h00);
    // R2 clear while condition held
    tag = "R2";
    step(1'b1, 8'h3E, 8'h10, 7'h08);
    idle(4, 8'h3C, 7'h08);
    idle(2, 8'h3C, 7'h00);
    // R3 supply flags follow their lines
    tag = "R3";
    idle(3, 8'h3C, 7'h01);
    idle(2, 8'h3C, 7'h02);
    idle(3, 8'h3C, 7'h00);
    // R4 sticky alarm then clear
    tag = "R4";
    step(1'b0, 8'h3D, 8'h00, 7'h20);
    idle(5, 8'h3D, 7'h00);
    step(1'b1, 8'h3E, 8'h10, 7'h00);
    idle(3, 8'h3D, 7'h00);
    // R10 software reset clears status
    tag = "R10";
    step(1'b0, 8'h3D, 8'h00, 7'h50);
    idle(2, 8'h3C, 7'h00);
    step(1'b1, 8'h3E, 8'h80, 7'h00);
    idle(2, 8'h3D, 7'h00);
    idle(2, 8'h3C, 7'h00);
    // R8 clean store, restarted mid-count
    tag = "R8";
    step(1'b1, 8'h3E, 8'h08, 7'h00);
    idle(HOLD / 2, 8'h3C, 7'h00);
    step(1'b1, 8'h3E, 8'h01, 7'h00);
    idle(HOLD + 3, 8'h3C, 7'h00);
    // R9 supply excursion during hold
    tag = "R9";
    step(1'b1, 8'h3E, 8'h02, 7'h00);
    idle(5, 8'h3C, 7'h00);
    idle(1, 8'h3C, 7'h02);
    idle(HOLD + 2, 8'h3C, 7'h00);
    step(1'b1, 8'h3E, 8'h10, 7'h00);
    idle(3, 8'h3C, 7'h00);
    // R1 random mix
    tag = "R1";
    for (int i = 0; i < 4000; i++) begin
      logic [6:0] ev;
      logic [7:0] a;
      ev = 7'h00;
      for (int b = 0; b < 7; b++)
        if ($urandom_range(0, (b < 2) ? 60 : 12) == 0) ev[b] = 1'b1;
      a = 8'h3C + 8'($urandom_range(0, 3));
      if ($urandom_range(0, 9) == 0)
        step(1'b1, ($urandom_range(0, 3) == 0) ? a : 8'h3E, 8'($urandom), ev);
      else
        step(1'b0, a, 8'h00, ev);
    end
    idle(2, 8'h3C, 7'h00);
    finish_run();
  end

endmodule